// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register transactions on a two-wire PHY management bus. A host presents a 5-bit PHY address, a 5-bit register address, 16 bits of write data and a read/write select, then pulses `start` for one cycle. The block generates the management clock `mdc` by dividing the system clock. It drives the serial line through a split output/enable pair, so a bidirectional pad can be built outside. When the frame is over it raises `done` for one cycle and, for a read, leaves the received register value on `rd_data`.

Every frame opens with a full preamble of 32 ones. A write then sends a 32-bit frame and idles the line for two more clock periods. A read sends a 14-bit header, releases the line and samples 19 bit times. Of those 19 samples it keeps the 16 data bits and discards the two turnaround samples and the trailing idle sample.

Top module: `mdio_master`

## Requirements
- R1: After reset `busy`, `done`, `mdc` and `mdio_oe` are 0 and `rd_data` is 0.
- R2: The first 32 bit times of every frame have `mdio_oe`=1 and `mdio_o`=1.
- R3: A write (`op_write`=1) drives the 32 bits 0,1,0,1, PHY address, register address, 1,0, write data, with each field MSB first and `mdio_oe`=1, in bit times 32 to 63.
- R4: A write is followed by exactly two more `mdc` periods with `mdio_oe`=0. The write frame has 66 rising `mdc` edges in total.
- R5: A read (`op_write`=0) drives 0,1,1,0, PHY address, register address, MSB first, in bit times 32 to 45. It then holds `mdio_oe`=0 for 19 bit times, giving 65 rising `mdc` edges in total.
- R6: On a read, the line is sampled once per released bit time. The samples for released bit times 2 to 17 form `rd_data`, MSB first. Released bit times 0, 1 and 18 are discarded.
- R7: While busy, `mdc` is low for `HALF_PERIOD` system cycles and then high for `HALF_PERIOD` cycles. It stays low while idle. The default of 20 gives 2.5 MHz from a 100 MHz clock.
- R8: `mdio_o` and `mdio_oe` change only while `mdc` is low. `mdio_i` is sampled in the last system cycle of the low phase, at the edge on which `mdc` rises.
- R9: A `start` pulse while `busy` is 1 is ignored: the frame in progress keeps its bits and length, and no second frame follows.
- R10: `busy` is 1 from the cycle after an accepted `start` until `done`. `done` is high for exactly one cycle, as `busy` falls. `rd_data` changes only at the end of a read and holds through later writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a frame |
| op_write | input | 1 | 1 = write, 0 = read |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write |
| rd_data | output | 16 | Data from the last read |
| done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the serial line |
| mdio_i | input | 1 | Serial data in |

## Verification
The bench builds the block with the default `HALF_PERIOD` of 20 on a 100 MHz clock. This puts `mdc` exactly at the 2.5 MHz limit, so the measured phase lengths check the rate bound itself. The long low phase gives the PHY model room to present a wrong value for 19 cycles and the correct value only in the final low cycle. That makes a sample taken one cycle early or late visible in `rd_data`. The model also drives the discarded turnaround and idle samples to values that would corrupt `rd_data` if they were kept.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_PERIOD = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_write,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        done,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int PRE      = 32;
  localparam int HDR_RD   = 14;
  localparam int WR_LEN   = PRE + 32 + 2;
  localparam int RD_LEN   = PRE + HDR_RD + 19;
  localparam int DIVW     = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

  logic [DIVW-1:0] div;
  logic            ph;
  logic [6:0]      bitn;
  logic            is_wr;
  logic [31:0]     frame;
  logic [18:0]     sh;

  wire        last_div  = (div == DIVW'(HALF_PERIOD - 1));
  wire [6:0]  flen      = is_wr ? 7'(WR_LEN) : 7'(RD_LEN);
  wire [6:0]  drive_len = is_wr ? 7'(PRE + 32) : 7'(PRE + HDR_RD);
  wire [6:0]  fi        = bitn - 7'(PRE);
  wire [4:0]  fidx      = 5'd31 - fi[4:0];

  assign mdc     = busy & ph;
  assign mdio_oe = busy && (bitn < drive_len);
  assign mdio_o  = mdio_oe && ((bitn < 7'(PRE)) ? 1'b1 : frame[fidx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      div     <= '0;
      ph      <= 1'b0;
      bitn    <= '0;
      is_wr   <= 1'b0;
      frame   <= '0;
      sh      <= '0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          is_wr <= op_write;
          frame <= op_write ? {4'b0101, phy_addr, reg_addr, 2'b10, wr_data}
                            : {4'b0110, phy_addr, reg_addr, 18'h0};
          bitn  <= '0;
          div   <= '0;
          ph    <= 1'b0;
        end
      end else if (!last_div) begin
        div <= div + DIVW'(1);
      end else begin
        div <= '0;
        if (!ph) begin
          ph <= 1'b1;
          if (!is_wr && !mdio_oe) sh <= {sh[17:0], mdio_i};
        end else begin
          ph <= 1'b0;
          if (bitn == flen - 7'd1) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (!is_wr) rd_data <= sh[16:1];
          end else begin
            bitn <= bitn + 7'd1;
          end
        end
      end
    end
  end

  a_r7_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r8_out_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r9_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(frame) && $stable(is_wr)));

  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> (done && !$past(is_wr)));

  a_r4_released_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !mdio_oe |-> !mdio_o);

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int HALF = 20;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0, op_write = 0;
  logic [4:0] phy_addr = 0, reg_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic done, busy, mdc, mdio_o, mdio_oe;
  logic mdio_i = 1;

  mdio_master #(.HALF_PERIOD(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_write(op_write),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .done(done), .busy(busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int rises = 0, done_cnt = 0, run = 0, mdc_bad = 0, hi_change = 0, lc = 0, cyc = 0;
  logic pm = 0, po = 0, poe = 0;
  logic rec_o [0:79];
  logic rec_oe[0:79];
  logic [15:0] phy_val = 16'h0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (mdc && !pm) begin
      if (rises < 80) begin rec_o[rises] = mdio_o; rec_oe[rises] = mdio_oe; end
      rises++;
    end
    if (mdc && pm && (mdio_o != po || mdio_oe != poe)) hi_change++;
    if (mdc != pm) begin
      if (run != HALF) mdc_bad++;
      run = 1;
    end else run++;
    if (!busy && !mdc) run = 0;
    if (done) done_cnt++;
    if (mdc) lc = 0; else lc++;
    begin
      logic good;
      int k;
      k = rises - 46;
      if (k < 0 || k > 18) good = 1'b1;
      else if (k == 0) good = 1'b1;
      else if (k == 1) good = 1'b0;
      else if (k == 18) good = 1'b1;
      else good = phy_val[15 - (k - 2)];
      mdio_i = (lc == HALF) ? good : ~good;
    end
    pm = mdc; po = mdio_o; poe = mdio_oe;
  end

  task automatic run_frame(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] d, input logic poke);
    @(negedge clk);
    rises = 0; done_cnt = 0; mdc_bad = 0; hi_change = 0;
    op_write = wr; phy_addr = pa; reg_addr = ra; wr_data = d; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R10 busy after start", busy, 1);
    if (poke) begin
      repeat (300) @(negedge clk);
      op_write = ~wr; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~d; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    repeat (3 * HALF) @(negedge clk);
    chk(done_cnt == 1, "R10 done width", done_cnt, 1);
    chk(busy == 0, "R9 no second frame", busy, 0);
    chk(mdc_bad == 0, "R7 mdc phase length", mdc_bad, 0);
    chk(hi_change == 0, "R8 output stable while mdc high", hi_change, 0);
  endtask

  task automatic check_bits(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] d, input string tag);
    logic [31:0] f;
    int bad_pre = 0, bad_hdr = 0, bad_rel = 0;
    f = wr ? {4'b0101, pa, ra, 2'b10, d} : {4'b0110, pa, ra, 18'h0};
    for (int i = 0; i < 32; i++) if (rec_o[i] !== 1'b1 || rec_oe[i] !== 1'b1) bad_pre++;
    chk(bad_pre == 0, "R2 preamble ones", bad_pre, 0);
    if (wr) begin
      for (int i = 0; i < 32; i++)
        if (rec_o[32+i] !== f[31-i] || rec_oe[32+i] !== 1'b1) bad_hdr++;
      for (int i = 64; i < 66; i++) if (rec_oe[i] !== 1'b0) bad_rel++;
      chk(bad_hdr == 0, {"R3 write frame bits ", tag}, bad_hdr, 0);
      chk(bad_rel == 0, "R4 idle after write", bad_rel, 0);
      chk(rises == 66, "R4 write length", rises, 66);
    end else begin
      for (int i = 0; i < 14; i++)
        if (rec_o[32+i] !== f[31-i] || rec_oe[32+i] !== 1'b1) bad_hdr++;
      for (int i = 46; i < 65; i++) if (rec_oe[i] !== 1'b0) bad_rel++;
      chk(bad_hdr == 0, {"R5 read header bits ", tag}, bad_hdr, 0);
      chk(bad_rel == 0, "R5 released bits", bad_rel, 0);
      chk(rises == 65, "R5 read length", rises, 65);
    end
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && mdc == 0 && mdio_oe == 0, "R1 control idle",
        {busy, done, mdc, mdio_oe}, 0);
    chk(rd_data == 16'h0, "R1 rd_data reset", rd_data, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    run_frame(1'b1, pa, ra, d, 1'b0);
    check_bits(1'b1, pa, ra, d, "plain");
  endtask

  task automatic t_read(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] v);
    phy_val = v;
    run_frame(1'b0, pa, ra, 16'h0, 1'b0);
    check_bits(1'b0, pa, ra, 16'h0, "plain");
    chk(rd_data == v, "R6 read data with sampling instant", rd_data, v);
  endtask

  task automatic t_ignore;
    run_frame(1'b1, 5'h0A, 5'h15, 16'hC33C, 1'b1);
    check_bits(1'b1, 5'h0A, 5'h15, 16'hC33C, "with start while busy (R9)");
  endtask

  task automatic t_hold;
    logic [15:0] keep;
    keep = rd_data;
    run_frame(1'b1, 5'h01, 5'h02, 16'h5A5A, 1'b0);
    chk(rd_data == keep, "R10 rd_data held over write", rd_data, keep);
    repeat (50) @(negedge clk);
    chk(rd_data == keep, "R10 rd_data held idle", rd_data, keep);
  endtask

  task automatic t_idle_start_drop;
    phy_val = 16'h0000;
    t_read(5'h00, 5'h00, 16'h0000);
    t_read(5'h1F, 5'h1F, 16'hFFFF);
  endtask

  initial begin
    t_reset();
    t_write(5'h1F, 5'h00, 16'hA5F0);
    t_write(5'h00, 5'h1F, 16'h0001);
    t_read(5'h11, 5'h0A, 16'hBEEF);
    t_read(5'h05, 5'h13, 16'h8001);
    t_idle_start_drop();
    t_ignore();
    t_read(5'h03, 5'h04, 16'h1234);
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule